// File: doc/BRIEF.md
# H-Bridge Leg Controller with Latched Faults

This block is the digital core of a full-bridge motor driver. It turns two direction inputs, a PWM input and two per-leg enables into four switch commands: a high-side and a low-side command for each of the two legs. When a leg's direction input is high, that leg's output is pulled to supply. When it is low, the leg's output is pulled to ground. The two legs together give clockwise and counterclockwise drive, brake to supply and brake to ground. The PWM input acts only on the low-side switches, so the motor speed can be modulated in any drive state.

Each leg watches two fault flags: a high-side overtemperature flag, and a low-side overcurrent flag that must persist for a filter time before it counts. A fault latches that leg off and pulls its diagnostic line low. The latch releases only on a rising edge of that leg's own direction input. An undervoltage detector, with separate trip and recovery comparator flags, switches off the whole bridge.

Every input passes through a two-flop synchroniser first. No switch turns on until a dead time has passed with both switches of its leg off, so the two switches of one leg are never on together.

Top module: `hb_bridge_ctrl`

## Requirements
- R1: With the leg enabled, no fault, no undervoltage and PWM high, a leg whose direction bit is 1 has its high-side command on and its low-side command off, and a leg whose direction bit is 0 has the reverse. Bit 0 of every two-bit port is leg A and bit 1 is leg B.
- R2: While the synchronised PWM input is low, both low-side commands are off and the high-side commands are unaffected. When PWM returns high, the low-side commands follow the direction bits again.
- R3: A low enable bit turns both switches of that leg off and raises that leg's `leg_hiz` bit. It does not pull that leg's diagnostic line, and it has no effect on the other leg.
- R4: A high-side overtemperature flag on a leg latches a fault: that leg's `diag_pull` bit goes high, both its switches turn off and its `leg_hiz` bit goes high. The other leg keeps running.
- R5: A latched fault stays set after its flag is removed. It survives a falling edge of its own direction bit and any edge of the other leg's direction bit. It clears only on a rising edge of its own direction bit after the flag is gone. A flag that is still present holds the fault set.
- R6: A low-side overcurrent flag latches the fault of its leg only after it has been high for `OC_FILTER` consecutive synchronised cycles. A shorter burst leaves the leg running.
- R7: A high `uv_trip` turns all four switches off and raises both `leg_hiz` bits, without pulling either diagnostic line. The bridge stays off after `uv_trip` falls, and runs again only once `uv_clear` has been high.
- R8: The high-side and low-side commands of one leg are never on together. Every turn-on is preceded by at least `DEAD`+1 cycles in which both switches of that leg are off.
- R9: While `rst` is high, all four switch commands are off, both `leg_hiz` bits are high and every fault latch and the undervoltage state are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir | input | 2 | Direction bit per leg (1 = output to supply) |
| pwm | input | 1 | PWM input gating both low-side switches |
| en | input | 2 | Active-high leg enable |
| hs_ot | input | 2 | High-side overtemperature flag per leg |
| ls_oc | input | 2 | Low-side overcurrent flag per leg |
| uv_trip | input | 1 | Supply below the shutdown threshold |
| uv_clear | input | 1 | Supply above the recovery threshold |
| hs_on | output | 2 | High-side switch command per leg |
| ls_on | output | 2 | Low-side switch command per leg |
| leg_hiz | output | 2 | Leg is in high impedance |
| diag_pull | output | 2 | Diagnostic pull-down, high while the leg fault is latched |

## Verification
All four direction combinations are applied with PWM high. These separate the two brake states from the two drive directions and show that each leg decodes only its own bit. The same drive states are then repeated with PWM low and with one enable low, which shows that PWM removes only the low-side commands and that an enable removes only its own leg. Fault sequences apply a flag, remove it, and then toggle the other leg's direction bit and the faulty leg's bit downward and upward in turn. Only the last of these steps may release the latch. An overcurrent burst shorter than the filter is contrasted with one longer than the filter.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    DRV_OFF  = 2'd0,
    DRV_HIGH = 2'd1,
    DRV_LOW  = 2'd2
  } leg_drive_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hb_oc_filter.sv
module hb_oc_filter #(
  parameter int OC_FILTER = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_s,
  output logic trip
);
  localparam int CW = $clog2(OC_FILTER + 1);
  localparam logic [CW-1:0] LIMIT = CW'(OC_FILTER);

  logic [CW-1:0] run_cnt;

  // consecutive-cycle counter, cleared by any low sample
  always_ff @(posedge clk) begin
    if (rst || !oc_s)
      run_cnt <= '0;
    else if (run_cnt != LIMIT)
      run_cnt <= run_cnt + 1'b1;
  end

  assign trip = (run_cnt == LIMIT);
endmodule

// File: rtl/hb_leg.sv
module hb_leg #(
  parameter int DEAD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic dir_s,
  input  logic en_s,
  input  logic pwm_s,
  input  logic hs_ot_s,
  input  logic oc_trip,
  input  logic uv_lat,
  output logic hs_on,
  output logic ls_on,
  output logic hiz,
  output logic diag
);
  import hb_pkg::*;

  localparam int DW = $clog2(DEAD + 2);
  localparam logic [DW-1:0] DEAD_V = DW'(DEAD);

  logic          dir_prev;
  logic          fault;
  logic          dir_rise;
  logic          active;
  logic          gap_done;
  logic [DW-1:0] dead_cnt;
  leg_drive_e    want;

  assign dir_rise = dir_s & ~dir_prev;
  assign active   = en_s & ~fault & ~uv_lat;
  assign gap_done = ~hs_on & ~ls_on & (dead_cnt == DEAD_V);

  always_comb begin
    if (!active)
      want = DRV_OFF;
    else if (dir_s)
      want = DRV_HIGH;
    else if (pwm_s)
      want = DRV_LOW;
    else
      want = DRV_OFF;
  end

  // fault latch: a present flag wins over a clearing edge
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_prev <= 1'b0;
      fault    <= 1'b0;
    end else begin
      dir_prev <= dir_s;
      if (hs_ot_s || oc_trip)
        fault <= 1'b1;
      else if (dir_rise)
        fault <= 1'b0;
    end
  end

  // switch commands: turn-off at once, turn-on only after the dead gap
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_on    <= 1'b0;
      ls_on    <= 1'b0;
      hiz      <= 1'b1;
      dead_cnt <= '0;
    end else begin
      hiz <= ~active;
      if (want != DRV_HIGH)
        hs_on <= 1'b0;
      else if (gap_done)
        hs_on <= 1'b1;
      if (want != DRV_LOW)
        ls_on <= 1'b0;
      else if (gap_done)
        ls_on <= 1'b1;
      if (hs_on || ls_on)
        dead_cnt <= '0;
      else if (dead_cnt != DEAD_V)
        dead_cnt <= dead_cnt + 1'b1;
    end
  end

  assign diag = fault;
endmodule

// File: rtl/hb_bridge_ctrl.sv
module hb_bridge_ctrl #(
  parameter int DEAD      = 4,
  parameter int OC_FILTER = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] dir,
  input  logic       pwm,
  input  logic [1:0] en,
  input  logic [1:0] hs_ot,
  input  logic [1:0] ls_oc,
  input  logic       uv_trip,
  input  logic       uv_clear,
  output logic [1:0] hs_on,
  output logic [1:0] ls_on,
  output logic [1:0] leg_hiz,
  output logic [1:0] diag_pull
);
  localparam int LEGS = 2;
  localparam int SW   = 4 * LEGS + 3;

  logic [SW-1:0]   raw_in;
  logic [SW-1:0]   sync_in;
  logic [LEGS-1:0] dir_s, en_s, ot_s, oc_s, oc_trip;
  logic            pwm_s, uvt_s, uvc_s;
  logic            uv_lat;

  assign raw_in = {uv_clear, uv_trip, pwm, ls_oc, hs_ot, en, dir};

  hb_sync #(.W(SW)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_in)
  );

  assign {uvc_s, uvt_s, pwm_s, oc_s, ot_s, en_s, dir_s} = sync_in;

  // undervoltage with hysteresis: trip below low threshold, release above high
  always_ff @(posedge clk) begin
    if (rst)
      uv_lat <= 1'b0;
    else if (uvt_s)
      uv_lat <= 1'b1;
    else if (uvc_s)
      uv_lat <= 1'b0;
  end

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    hb_oc_filter #(.OC_FILTER(OC_FILTER)) filt_i (
      .clk  (clk),
      .rst  (rst),
      .oc_s (oc_s[g]),
      .trip (oc_trip[g])
    );

    hb_leg #(.DEAD(DEAD)) leg_i (
      .clk     (clk),
      .rst     (rst),
      .dir_s   (dir_s[g]),
      .en_s    (en_s[g]),
      .pwm_s   (pwm_s),
      .hs_ot_s (ot_s[g]),
      .oc_trip (oc_trip[g]),
      .uv_lat  (uv_lat),
      .hs_on   (hs_on[g]),
      .ls_on   (ls_on[g]),
      .hiz     (leg_hiz[g]),
      .diag    (diag_pull[g])
    );
  end
endmodule

// File: rtl/hb_bridge_chk.sv
module hb_bridge_chk #(
  parameter int DEAD = 4
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] hs_on,
  input logic [1:0] ls_on,
  input logic [1:0] leg_hiz,
  input logic [1:0] diag_pull,
  input logic       pwm_s,
  input logic [1:0] en_s,
  input logic [1:0] dir_s,
  input logic       uv_lat
);
  localparam int GW = $clog2(DEAD + 3);
  localparam logic [GW-1:0] GAP_MIN = GW'(DEAD + 1);

  p_reset_off_r9: assert property (@(posedge clk)
    $past(rst) |-> (hs_on == 2'b00 && ls_on == 2'b00 && diag_pull == 2'b00));

  p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
    (hs_on & ls_on) == 2'b00);

  p_pwm_gate_r2: assert property (@(posedge clk) disable iff (rst)
    !pwm_s |=> ls_on == 2'b00);

  p_uv_off_r7: assert property (@(posedge clk) disable iff (rst)
    uv_lat |=> (hs_on == 2'b00 && ls_on == 2'b00 && leg_hiz == 2'b11));

  for (genvar i = 0; i < 2; i++) begin : g_chk
    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
      if (rst || hs_on[i] || ls_on[i])
        gap <= '0;
      else if (gap != GAP_MIN)
        gap <= gap + 1'b1;
    end

    p_dead_gap_r8: assert property (@(posedge clk) disable iff (rst)
      ($rose(hs_on[i]) || $rose(ls_on[i])) |-> gap == GAP_MIN);

    p_enable_off_r3: assert property (@(posedge clk) disable iff (rst)
      !en_s[i] |=> (!hs_on[i] && !ls_on[i] && leg_hiz[i]));

    p_fault_off_r4: assert property (@(posedge clk) disable iff (rst)
      diag_pull[i] |=> (!hs_on[i] && !ls_on[i] && leg_hiz[i]));

    p_fault_clear_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(diag_pull[i]) |-> ($past(dir_s[i]) && !$past(dir_s[i], 2)));
  end
endmodule

bind hb_bridge_ctrl hb_bridge_chk #(.DEAD(DEAD)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .hs_on     (hs_on),
  .ls_on     (ls_on),
  .leg_hiz   (leg_hiz),
  .diag_pull (diag_pull),
  .pwm_s     (pwm_s),
  .en_s      (en_s),
  .dir_s     (dir_s),
  .uv_lat    (uv_lat)
);

// File: tb/hb_bridge_ctrl_tb_top.sv
module hb_bridge_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEAD       = 4;
  localparam int OC_FILTER  = 1000;
  localparam int SETTLE     = 20;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] dir = 2'b00;
  logic       pwm = 1'b1;
  logic [1:0] en = 2'b11;
  logic [1:0] hs_ot = 2'b00;
  logic [1:0] ls_oc = 2'b00;
  logic       uv_trip = 1'b0;
  logic       uv_clear = 1'b0;
  logic [1:0] hs_on, ls_on, leg_hiz, diag_pull;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  item_t sb_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  hb_bridge_ctrl #(.DEAD(DEAD), .OC_FILTER(OC_FILTER)) dut_i (
    .clk (clk), .rst (rst), .dir (dir), .pwm (pwm), .en (en),
    .hs_ot (hs_ot), .ls_oc (ls_oc), .uv_trip (uv_trip), .uv_clear (uv_clear),
    .hs_on (hs_on), .ls_on (ls_on), .leg_hiz (leg_hiz), .diag_pull (diag_pull)
  );

  // expected word: {diag_pull, leg_hiz, ls_on, hs_on}
  task automatic expect_after(input logic [7:0] e, input string tag);
    item_t it;
    repeat (SETTLE) @(posedge clk);
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sb_q.pop_front();
      act = {diag_pull, leg_hiz, ls_on, hs_on};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%b expected=%b", it.tag, act, it.exp);
      end
    end
  end

  // dead-time and overlap monitor (R8)
  int gap[2] = '{0, 0};
  logic [1:0] hs_prev = 2'b00, ls_prev = 2'b00;
  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if ((hs_on[i] && !hs_prev[i]) || (ls_on[i] && !ls_prev[i])) begin
        checks++;
        if (gap[i] < DEAD + 1 || (hs_on[i] && ls_on[i])) begin
          errors++;
          $display("FAIL R8 leg%0d actual gap=%0d overlap=%b expected gap>=%0d overlap=0",
                   i, gap[i], hs_on[i] & ls_on[i], DEAD + 1);
        end
      end
      if (hs_on[i] || ls_on[i]) gap[i] = 0;
      else gap[i] = gap[i] + 1;
    end
    hs_prev = hs_on;
    ls_prev = ls_on;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    expect_after(8'b00_11_00_00, "R9 reset");
    @(negedge clk) rst = 1'b0;
    // R1: brake to ground, clockwise, counterclockwise, brake to supply
    expect_after(8'b00_00_11_00, "R1 both low");
    @(negedge clk) dir = 2'b01;
    expect_after(8'b00_00_10_01, "R1 A high");
    @(negedge clk) dir = 2'b10;
    expect_after(8'b00_00_01_10, "R1 B high");
    @(negedge clk) dir = 2'b11;
    expect_after(8'b00_00_00_11, "R1 both high");
    // R2: PWM gates low sides only
    @(negedge clk) begin dir = 2'b01; pwm = 1'b0; end
    expect_after(8'b00_00_00_01, "R2 pwm low");
    @(negedge clk) pwm = 1'b1;
    expect_after(8'b00_00_10_01, "R2 pwm back");
    // R3: leg B disabled
    @(negedge clk) en = 2'b01;
    expect_after(8'b00_10_00_01, "R3 B disabled");
    @(negedge clk) en = 2'b11;
    expect_after(8'b00_00_10_01, "R3 B enabled");
    // R4: overtemperature on leg A
    @(negedge clk) hs_ot = 2'b01;
    expect_after(8'b01_01_10_00, "R4 A overtemp");
    @(negedge clk) hs_ot = 2'b00;
    expect_after(8'b01_01_10_00, "R5 flag removed");
    // R5: other-leg edges and own falling edge do not clear
    @(negedge clk) dir = 2'b11;
    expect_after(8'b01_01_00_10, "R5 B rise");
    @(negedge clk) dir = 2'b01;
    expect_after(8'b01_01_10_00, "R5 B fall");
    @(negedge clk) dir = 2'b00;
    expect_after(8'b01_01_10_00, "R5 A fall");
    @(negedge clk) dir = 2'b01;
    expect_after(8'b00_00_10_01, "R5 A rise clears");
    // R5: a flag still present holds the fault through a rising edge
    @(negedge clk) hs_ot = 2'b01;
    expect_after(8'b01_01_10_00, "R5 refault");
    @(negedge clk) dir = 2'b00;
    expect_after(8'b01_01_10_00, "R5 fall with flag");
    @(negedge clk) dir = 2'b01;
    expect_after(8'b01_01_10_00, "R5 rise with flag");
    @(negedge clk) hs_ot = 2'b00;
    @(negedge clk) dir = 2'b00;
    @(negedge clk) dir = 2'b01;
    expect_after(8'b00_00_10_01, "R5 cleared");
    // R6: short overcurrent burst on leg B is filtered
    @(negedge clk) ls_oc = 2'b10;
    repeat (OC_FILTER / 2) @(negedge clk);
    ls_oc = 2'b00;
    expect_after(8'b00_00_10_01, "R6 short burst");
    // R6: long burst latches
    @(negedge clk) ls_oc = 2'b10;
    repeat (OC_FILTER + 50) @(negedge clk);
    ls_oc = 2'b00;
    expect_after(8'b10_10_00_01, "R6 long burst");
    @(negedge clk) dir = 2'b11;
    @(negedge clk) dir = 2'b01;
    expect_after(8'b00_00_10_01, "R6 B cleared");
    // R7: undervoltage with hysteresis
    @(negedge clk) uv_trip = 1'b1;
    expect_after(8'b00_11_00_00, "R7 uv trip");
    @(negedge clk) uv_trip = 1'b0;
    expect_after(8'b00_11_00_00, "R7 uv held");
    @(negedge clk) uv_clear = 1'b1;
    @(negedge clk) uv_clear = 1'b0;
    expect_after(8'b00_00_10_01, "R7 uv released");
    // R9: reset mid-run clears a latched fault
    @(negedge clk) hs_ot = 2'b10;
    expect_after(8'b10_10_00_01, "R9 pre-reset fault");
    @(negedge clk) begin hs_ot = 2'b00; rst = 1'b1; end
    expect_after(8'b00_11_00_00, "R9 reset mid-run");
    @(negedge clk) rst = 1'b0;
    expect_after(8'b00_00_10_01, "R9 after reset");

    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule